// File: doc/BRIEF.md
# Fixed-Topology Perceptron Inference Engine

The engine classifies one five-element sensor sample. A sample is offered on `inData` and taken when `start` is high and the engine is idle. It is copied into an input buffer, and the engine then computes three fully connected layers in turn:

- eight hidden neurons driven by the five inputs;
- eight hidden neurons driven by the first hidden layer;
- one output neuron driven by the second hidden layer.

A bank of eight signed multipliers serves every layer. The first layer uses the bank for five cycles, one input element per cycle, with lane k serving neuron k. The second layer uses it for eight cycles, one hidden value per cycle. The output layer needs one cycle, and an adder tree sums all eight lane products.

All data is signed fixed point, 16 bits wide with 12 fraction bits. Each product keeps its full 32-bit width and adds into a 36-bit accumulator. After accumulation the neuron adds its bias once, rounds, saturates and applies its activation. The weights and biases are constants computed at elaboration from the `SEED` parameter. The result appears on `outData` with a one-cycle `done` pulse, a fixed sixteen cycles after the start was taken.

Top module: `mlp_engine`

## Requirements
- R1: While `rstN` is low and after its release, `busy` and `done` are 0 and `outData` is 0.
- R2: A `start` seen high at a rising edge while `busy` is low is accepted. At that edge `inData` is captured (element i in bits [16i+15:16i]), and `busy` is high from the next cycle.
- R3: Both hidden layers apply ReLU. A neuron whose rounded, saturated sum is negative passes 0 to the next layer. Otherwise it passes the sum unchanged.
- R4: Each neuron sums the full-width products weight×value over all its inputs. It then adds its bias shifted left by 12, adds 2048 and shifts arithmetically right by 12. Finally it clamps the result to the range -32768..32767.
- R5: The output neuron applies no activation, so `outData` may be negative. It is the signed 16-bit result of R4 over the eight second-layer values.
- R6: The weight for layer L (1, 2 or 3), row r and column c is ((L·97 + r·31 + c·17 + SEED)·37 mod 8192) − 4096.
  - For layers 1 and 2, the row is the source input and the column is the neuron.
  - For layer 3, the row is 0 and the column is the source.
  - The bias for layer L, neuron n is ((L·53 + n·29 + SEED)·41 mod 4096) − 2048.
- R7: `done` is high for exactly one cycle. That cycle is the sixteenth cycle after the accepting edge, which means after fifteen more rising edges.
- R8: While `busy` is high, `start` is ignored and changes on `inData` do not affect the result in progress.
- R9: `outData` changes only when a new result is written, in the cycle where `done` rises. It holds that value until the next result.
- R10: `busy` falls in the cycle after the `done` pulse. A start is accepted again from that cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to classify the sample on `inData` |
| inData | input | 80 | Five signed Q4.12 inputs, element i in bits [16i+15:16i] |
| busy | output | 1 | High from the cycle after acceptance through the done cycle |
| done | output | 1 | One-cycle pulse marking a new result |
| outData | output | 16 | Signed Q4.12 output of the last neuron |

## Verification
Some properties are checked on every cycle:

- `done` is a single pulse that always lands a fixed distance from the accepting edge, and `busy` drops right after it.
- A busy engine cannot restart.
- The input buffer changes only on acceptance.
- The output register changes only on its write cycle.
- Both hidden buffers never hold a negative value.

The numeric behaviour can only be shown by the bench's scenarios. These cover the bias arithmetic, rounding, saturation at both rails, the negative linear output and the weight indexing. In those scenarios the bench compares the output against an independent integer model, for zero, unit, mixed, full-scale positive and full-scale negative samples. The scenarios also cover start held high across back-to-back runs, and input changes during a run.

// File: rtl/mlp_pkg.sv
package mlp_pkg;
  localparam int DATA_W = 16;
  localparam int FRAC_W = 12;
  localparam int PROD_W = 2 * DATA_W;
  localparam int ACC_W  = PROD_W + 4;
  localparam int IN_N   = 5;
  localparam int HID_N  = 8;
  localparam int LANES  = HID_N;
  localparam int STEP_W = $clog2(HID_N > IN_N ? HID_N : IN_N);
  // accept edge, load cycle, one cycle per layer step, done cycle
  localparam int LATENCY = 1 + IN_N + HID_N + 1 + 1;

  localparam logic signed [ACC_W-1:0] RND_HALF = ACC_W'(2 ** (FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] SAT_HI   = ACC_W'(2 ** (DATA_W - 1) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO   = ~SAT_HI;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_L1, ST_L2, ST_L3, ST_DONE
  } state_e;

  typedef enum logic [1:0] {
    LY_ONE, LY_TWO, LY_OUT
  } layer_e;

  typedef struct packed {
    logic              loadIn;
    logic              clearAcc;
    logic              accEn;
    logic              lastStep;
    layer_e            layer;
    logic [STEP_W-1:0] step;
  } ctrl_s;

  function automatic logic signed [DATA_W-1:0] romWeight(int layer, int row, int col, int seed);
    int raw;
    raw = (layer * 97 + row * 31 + col * 17 + seed) * 37;
    return DATA_W'((raw % 8192) - 4096);
  endfunction

  function automatic logic signed [DATA_W-1:0] romBias(int layer, int idx, int seed);
    int raw;
    raw = (layer * 53 + idx * 29 + seed) * 41;
    return DATA_W'((raw % 4096) - 2048);
  endfunction

  function automatic logic signed [ACC_W-1:0] alignBias(logic signed [DATA_W-1:0] b);
    return {{(ACC_W - DATA_W - FRAC_W){b[DATA_W-1]}}, b, {FRAC_W{1'b0}}};
  endfunction

  function automatic logic signed [DATA_W-1:0] roundSat(logic signed [ACC_W-1:0] v);
    logic signed [ACC_W-1:0] r;
    r = (v + RND_HALF) >>> FRAC_W;
    if (r > SAT_HI) return SAT_HI[DATA_W-1:0];
    if (r < SAT_LO) return SAT_LO[DATA_W-1:0];
    return r[DATA_W-1:0];
  endfunction

  function automatic logic signed [DATA_W-1:0] relu(logic signed [DATA_W-1:0] x);
    return x[DATA_W-1] ? '0 : x;
  endfunction
endpackage

// File: rtl/mlp_ctrl.sv
module mlp_ctrl
  import mlp_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  output logic  busy,
  output logic  done,
  output ctrl_s ctl
);
  state_e            state;
  logic [STEP_W-1:0] stepCnt;
  logic              l1Last, l2Last;

  assign l1Last = (state == ST_L1) && (stepCnt == STEP_W'(IN_N - 1));
  assign l2Last = (state == ST_L2) && (stepCnt == STEP_W'(HID_N - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) state <= ST_LOAD;
        ST_LOAD: begin
          state   <= ST_L1;
          stepCnt <= '0;
        end
        ST_L1: begin
          if (l1Last) begin
            state   <= ST_L2;
            stepCnt <= '0;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        ST_L2: begin
          if (l2Last) begin
            state   <= ST_L3;
            stepCnt <= '0;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        ST_L3:   state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.loadIn   = (state == ST_IDLE) && start;
    ctl.clearAcc = (state == ST_LOAD);
    ctl.accEn    = (state == ST_L1) || (state == ST_L2) || (state == ST_L3);
    ctl.lastStep = l1Last || l2Last || (state == ST_L3);
    ctl.step     = stepCnt;
    unique case (state)
      ST_L2:   ctl.layer = LY_TWO;
      ST_L3:   ctl.layer = LY_OUT;
      default: ctl.layer = LY_ONE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  // checker counter: edges since the accepting edge
  logic [5:0] sinceAccept;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceAccept <= '0;
    else if (!busy && start) sinceAccept <= '0;
    else if (busy && sinceAccept != 6'h3f) sinceAccept <= sinceAccept + 1'b1;
  end

  a_r7_done_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (sinceAccept == 6'(LATENCY - 1)));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadIn, ctl.clearAcc, ctl.accEn}));
endmodule

// File: rtl/mlp_datapath.sv
module mlp_datapath
  import mlp_pkg::*;
#(
  parameter int SEED = 7
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrl_s                          ctl,
  input  logic [IN_N-1:0][DATA_W-1:0]    inData,
  output logic [DATA_W-1:0]              outData
);
  localparam logic signed [DATA_W-1:0] OUT_BIAS = romBias(3, 0, SEED);

  logic signed [DATA_W-1:0] xBuf  [IN_N];
  logic signed [DATA_W-1:0] h1Vec [HID_N];
  logic signed [DATA_W-1:0] h2Vec [HID_N];
  logic signed [DATA_W-1:0] w1Rom [IN_N][HID_N];
  logic signed [DATA_W-1:0] w2Rom [HID_N][HID_N];
  logic signed [PROD_W-1:0] prod  [LANES];
  logic signed [ACC_W-1:0]  treeSum;
  logic signed [DATA_W-1:0] outReg;
  logic                     outLoad;

  for (genvar r = 0; r < IN_N; r++) begin : g_w1r
    for (genvar c = 0; c < HID_N; c++) begin : g_w1c
      assign w1Rom[r][c] = romWeight(1, r, c, SEED);
    end
  end

  for (genvar r = 0; r < HID_N; r++) begin : g_w2r
    for (genvar c = 0; c < HID_N; c++) begin : g_w2c
      assign w2Rom[r][c] = romWeight(2, r, c, SEED);
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic signed [DATA_W-1:0] BIAS1 = romBias(1, k, SEED);
    localparam logic signed [DATA_W-1:0] BIAS2 = romBias(2, k, SEED);
    localparam logic signed [DATA_W-1:0] WOUT  = romWeight(3, 0, k, SEED);

    logic signed [DATA_W-1:0] opW, opX;
    logic signed [ACC_W-1:0]  acc, accNext;
    logic signed [DATA_W-1:0] h1Q, h2Q;

    always_comb begin
      opW = w1Rom[ctl.step][k];
      opX = xBuf[ctl.step];
      unique case (ctl.layer)
        LY_TWO: begin
          opW = w2Rom[ctl.step][k];
          opX = h1Vec[ctl.step];
        end
        LY_OUT: begin
          opW = WOUT;
          opX = h2Vec[k];
        end
        default: ;
      endcase
    end

    assign prod[k] = PROD_W'(opW) * PROD_W'(opX);
    assign accNext = acc + ACC_W'(prod[k]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        acc <= '0;
        h1Q <= '0;
        h2Q <= '0;
      end else if (ctl.clearAcc) begin
        acc <= '0;
      end else if (ctl.accEn) begin
        if (ctl.lastStep) begin
          acc <= '0;
          if (ctl.layer == LY_ONE) h1Q <= relu(roundSat(accNext + alignBias(BIAS1)));
          if (ctl.layer == LY_TWO) h2Q <= relu(roundSat(accNext + alignBias(BIAS2)));
        end else begin
          acc <= accNext;
        end
      end
    end

    assign h1Vec[k] = h1Q;
    assign h2Vec[k] = h2Q;

    a_r3_hidden_nonneg: assert property (@(posedge clk) disable iff (!rstN)
      !h1Q[DATA_W-1] && !h2Q[DATA_W-1]);
  end

  // output neuron: all lanes summed in one cycle
  always_comb begin
    treeSum = '0;
    for (int k = 0; k < LANES; k++) treeSum = treeSum + ACC_W'(prod[k]);
  end

  assign outLoad = ctl.accEn && ctl.lastStep && (ctl.layer == LY_OUT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
      for (int i = 0; i < IN_N; i++) xBuf[i] <= '0;
    end else begin
      if (ctl.loadIn) begin
        for (int i = 0; i < IN_N; i++) xBuf[i] <= $signed(inData[i]);
      end
      if (outLoad) outReg <= roundSat(treeSum + alignBias(OUT_BIAS));
    end
  end

  assign outData = outReg;

  a_r9_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outLoad |=> $stable(outReg));

  for (genvar i = 0; i < IN_N; i++) begin : g_chk_in
    a_r8_input_frozen: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.loadIn |=> $stable(xBuf[i]));
  end
endmodule

// File: rtl/mlp_engine.sv
module mlp_engine
  import mlp_pkg::*;
#(
  parameter int SEED = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [IN_N-1:0][DATA_W-1:0] inData,
  output logic                        busy,
  output logic                        done,
  output logic [DATA_W-1:0]           outData
);
  ctrl_s ctl;

  mlp_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .busy  (busy),
    .done  (done),
    .ctl   (ctl)
  );

  mlp_datapath #(.SEED(SEED)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .inData  (inData),
    .outData (outData)
  );
endmodule

// File: tb/sim_mlp_engine.sv
`timescale 1ns/1ps
module sim_mlp_engine;
  localparam int SEED = 7;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [4:0][15:0] inData = '0;
  logic             busy, done;
  logic [15:0]      outData;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  bit running  = 0;

  always #2.5 clk = ~clk;

  mlp_engine #(.SEED(SEED)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .inData(inData),
    .busy(busy), .done(done), .outData(outData)
  );

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R6 coefficient formulas
  function automatic int wgt(int ly, int r, int c);
    return (((ly * 97 + r * 31 + c * 17 + SEED) * 37) % 8192) - 4096;
  endfunction
  function automatic int bia(int ly, int n);
    return (((ly * 53 + n * 29 + SEED) * 41) % 4096) - 2048;
  endfunction
  // R4 neuron finishing
  function automatic int finish16(longint s);
    longint q;
    q = (s + 2048) >>> 12;
    if (q > 32767) return 32767;
    if (q < -32768) return -32768;
    return int'(q);
  endfunction

  function automatic int infer(int x[5]);
    int h1[8], h2[8];
    longint s;
    for (int n = 0; n < 8; n++) begin
      s = 0;
      for (int i = 0; i < 5; i++) s += longint'(wgt(1, i, n)) * x[i];
      h1[n] = finish16(s + (longint'(bia(1, n)) <<< 12));
      if (h1[n] < 0) h1[n] = 0;                       // R3
    end
    for (int n = 0; n < 8; n++) begin
      s = 0;
      for (int i = 0; i < 8; i++) s += longint'(wgt(2, i, n)) * h1[i];
      h2[n] = finish16(s + (longint'(bia(2, n)) <<< 12));
      if (h2[n] < 0) h2[n] = 0;
    end
    s = 0;
    for (int i = 0; i < 8; i++) s += longint'(wgt(3, 0, i)) * h2[i];
    return finish16(s + (longint'(bia(3, 0)) <<< 12)); // R5 linear
  endfunction

  // cycle model
  bit mBusy = 0, mDone = 0;
  int mCnt = 0, mRes = 0, mOut = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mCnt = 0; mOut = 0;
    end else if (!mBusy) begin
      if (start) begin
        int mx[5];
        for (int i = 0; i < 5; i++) mx[i] = int'($signed(inData[i]));
        mRes = infer(mx);
        mBusy = 1; mCnt = 0;
      end
    end else begin
      mCnt++;
      mDone = (mCnt == 15);
      if (mCnt == 15) mOut = mRes;
      if (mCnt == 16) mBusy = 0;
    end
  end

  always @(negedge clk) begin
    if (rstN && running) begin
      check(busy === mBusy, "R2 R10 busy", busy, mBusy);
      check(done === mDone, "R7 done", done, mDone);
      check($signed(outData) === 16'(mOut), "R9 outData", $signed(outData), mOut);
    end
  end

  task automatic runOne(int x[5], string tag);
    int lat;
    @(negedge clk);
    for (int i = 0; i < 5; i++) inData[i] = 16'(x[i]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, {"R2 busy after accept ", tag}, busy, 1);
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
      if (lat == 4) begin
        inData = {5{16'h7abc}};   // R8 stray data mid-run
        start = 1'b1;
      end
      if (lat == 5) start = 1'b0;
    end
    check(lat == 16, {"R7 latency ", tag}, lat, 16);
    check($signed(outData) == 16'(infer(x)), {"R3 R4 R5 result ", tag},
          $signed(outData), infer(x));
    @(negedge clk);
    check(busy === 1'b0, {"R10 idle ", tag}, busy, 0);
    check($signed(outData) == 16'(infer(x)), {"R9 hold ", tag}, $signed(outData), infer(x));
  endtask

  initial begin
    int v[5];
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && outData === 16'h0, "R1 during reset",
          {busy, done, outData}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && outData === 16'h0, "R1 after reset",
          {busy, done, outData}, 0);
    running = 1;
    v = '{0, 0, 0, 0, 0};                 runOne(v, "zero");
    v = '{4096, 4096, 4096, 4096, 4096};  runOne(v, "unit");
    v = '{-4096, 2048, 8192, -12000, 300}; runOne(v, "mixed");
    v = '{32767, 32767, 32767, 32767, 32767}; runOne(v, "posrail");
    v = '{-32768, -32768, -32768, -32768, -32768}; runOne(v, "negrail");
    v = '{-20000, 20000, -20000, 20000, -20000}; runOne(v, "alternate");
    v = '{1, -1, 2, -2, 3};               runOne(v, "tiny");
    // R8 start held high across back-to-back runs; model checks every cycle
    @(negedge clk);
    inData = {16'd5000, 16'hf000, 16'd123, 16'd9000, 16'hc000};
    start = 1'b1;
    repeat (45) @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule